// File: doc/BRIEF.md
# SPI Serial Clock and Chip-Select Timing Generator

This block produces the serial clock and the chip-select framing intervals for a SPI master. A single 31-bit attribute word holds every timing setting: the clock-rate prescaler and scaler, three delay prescaler and scaler pairs, clock polarity, clock phase, bit order and frame length. The word is captured when a start pulse is accepted. Later changes on the attribute input have no effect until the next start.

After a start is accepted, the block runs four intervals in a fixed order: a lead delay from chip-select assertion to the first clock edge, the clocked bits, a trail delay after the last edge, and a gap before the next frame may begin. During clocking it gives single-cycle shift and sample strobes to a separate data shifter. When the gap ends it raises a one-cycle done pulse. The divider codes arrive already encoded. The block does not derive them from a target frequency.

Top module: `spi_timing_gen`

## Requirements
- R1: While reset is asserted and after it is released, sck_o, cs_active_o, busy_o, shift_o, sample_o, lsb_first_o and done_o are all low.
- R2: While idle, sck_o rests at the polarity bit (bit 26) of the last accepted attribute word. Changing attr_i without a start leaves sck_o unchanged.
- R3: A start is accepted only while busy_o is low. A start pulse during a frame is ignored, and no second frame follows.
- R4: A frame runs lead, clocking, trail and gap in that order. cs_active_o is high during lead, clocking and trail. busy_o is high during all four intervals.
- R5: Each delay lasts P × 2^(S+1) clock cycles. P is a 2-bit code selecting 1, 3, 5 or 7, and S is a 4-bit code. The lead uses P at bits 23:22 and S at bits 15:12. The trail uses bits 21:20 and 11:8. The gap uses bits 19:18 and 7:4.
- R6: One bit lasts D = B × C cycles, and each half of the bit lasts D/2 cycles. B is taken from bits 17:16 and selects 2, 3, 5 or 7. C is taken from bits 3:0: codes 0, 1 and 2 select 2, 4 and 6, and a code k of 3 or more selects 2^k.
- R7: The number of clocked bits is the field at bits 30:27 plus one. Field values 0, 1 and 2 give 4 bits.
- R8: With phase bit 25 clear, sck_o leaves its idle level at the middle of each bit. sample_o pulses there, and shift_o pulses at each return edge between bits, which gives N−1 shifts. With bit 25 set, sck_o leaves its idle level at the start of each bit. shift_o pulses there (N shifts) and sample_o pulses at mid-bit.
- R9: sck_o is away from its idle level for D/2 cycles per bit. The last sck_o change comes at the start of the trail when bit 25 is clear, and D/2 cycles before the trail when bit 25 is set.
- R10: lsb_first_o follows bit 24 of the accepted attribute word and holds that value throughout the frame.
- R11: done_o pulses high for exactly one cycle, in the first cycle after the gap, with busy_o already low.
- R12: A change on attr_i during a frame does not alter that frame's timing, polarity or bit order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; every interval is counted in its cycles |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Frame request, taken only when idle |
| attr_i | input | 31 | Attribute word with the divider, delay, mode and frame-length fields |
| sck_o | output | 1 | Serial clock |
| cs_active_o | output | 1 | High while the chip select should be asserted |
| busy_o | output | 1 | High from acceptance until the gap ends |
| shift_o | output | 1 | Strobe to present the next data bit |
| sample_o | output | 1 | Strobe to capture the incoming data bit |
| lsb_first_o | output | 1 | Bit order of the frame in progress |
| done_o | output | 1 | One-cycle pulse after the gap |

## Verification
The assertions assume that start_i and attr_i change only between clock edges. They also assume that the counter width can hold the longest delay, which an elaboration check enforces. The assertions depend on every interval being at least two cycles long. The encodings make this true: every scaler is even and every delay has a factor of at least two. The stimulus drives all inputs at the falling edge and uses only legal attribute words. It covers both polarities, both phases, both bit orders and the frame-length clamp. Stray starts and attribute changes are placed inside frames, and back-to-back starts are placed in the done cycle.

// File: rtl/sctg_pkg.sv
package sctg_pkg;

   localparam int ATTR_W    = 31;
   localparam int MIN_BITS  = 4;
   localparam int MAX_BITS  = 16;
   localparam int BITS_W    = $clog2(MAX_BITS + 1);
   localparam int CNT_W_MIN = 19;   // 7 * 2^16 delay cycles must fit

   // attribute field positions (decoded by this block only)
   localparam int FS_LSB     = 27;
   localparam int POL_BIT    = 26;
   localparam int PHA_BIT    = 25;
   localparam int ORD_BIT    = 24;
   localparam int BR_PRE_LSB = 16;
   localparam int BR_SCL_LSB = 0;
   localparam int NUM_DLY    = 3;   // 0: lead, 1: trail, 2: gap

   typedef enum logic [2:0] {
      PH_IDLE, PH_LEAD, PH_CLOCK, PH_TRAIL, PH_GAP
   } phase_e;

   function automatic int dly_pre_lsb(int k);
      return 22 - 2 * k;
   endfunction

   function automatic int dly_scl_lsb(int k);
      return 12 - 4 * k;
   endfunction

   // 1, 3, 5, 7
   function automatic logic [2:0] odd_pre(logic [1:0] c);
      return {c, 1'b1};
   endfunction

   // 2, 3, 5, 7
   function automatic logic [2:0] baud_pre(logic [1:0] c);
      case (c)
         2'd0:    return 3'd2;
         2'd1:    return 3'd3;
         2'd2:    return 3'd5;
         default: return 3'd7;
      endcase
   endfunction

   // half of the baud scaler: 1, 2, 3, then 2^(c-1)
   function automatic logic [14:0] half_scl(logic [3:0] c);
      if (c < 4'd3) return 15'(c) + 15'd1;
      else          return 15'd1 << (c - 4'd1);
   endfunction

endpackage

// File: rtl/sctg_attr_decode.sv
module sctg_attr_decode
   import sctg_pkg::*;
#(
   parameter int CNT_W = 20
) (
   input  logic [ATTR_W-1:0]             attr,
   output logic [CNT_W-1:0]              half_len,
   output logic [NUM_DLY-1:0][CNT_W-1:0] dly_len,
   output logic [BITS_W-1:0]             nbits,
   output logic                          cpol,
   output logic                          cpha,
   output logic                          lsb
);

   logic [3:0] fs;

   assign cpol = attr[POL_BIT];
   assign cpha = attr[PHA_BIT];
   assign lsb  = attr[ORD_BIT];
   assign fs   = attr[FS_LSB +: 4];

   assign nbits = (fs < 4'd3) ? BITS_W'(MIN_BITS) : BITS_W'(fs) + BITS_W'(1);

   assign half_len = CNT_W'(baud_pre(attr[BR_PRE_LSB +: 2]))
                   * CNT_W'(half_scl(attr[BR_SCL_LSB +: 4]));

   for (genvar k = 0; k < NUM_DLY; k++) begin : g_dly
      localparam int PL = dly_pre_lsb(k);
      localparam int SL = dly_scl_lsb(k);
      assign dly_len[k] = CNT_W'(odd_pre(attr[PL +: 2]))
                        << ({1'b0, attr[SL +: 4]} + 5'd1);
   end

endmodule

// File: rtl/sctg_span_cnt.sv
module sctg_span_cnt #(
   parameter int W = 20
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         restart,
   input  logic         step,
   input  logic [W-1:0] len,
   output logic         first,
   output logic         last
);

   logic [W-1:0] cnt_q;

   assign first = (cnt_q == '0);
   assign last  = (cnt_q == len - W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt_q <= '0;
      else if (restart) cnt_q <= '0;
      else if (step)    cnt_q <= last ? '0 : cnt_q + W'(1);
   end

   AST_SPAN_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q < len);   // R5

endmodule

// File: rtl/spi_timing_gen.sv
module spi_timing_gen
   import sctg_pkg::*;
#(
   parameter int CNT_W = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              start_i,
   input  logic [ATTR_W-1:0] attr_i,
   output logic              sck_o,
   output logic              cs_active_o,
   output logic              busy_o,
   output logic              shift_o,
   output logic              sample_o,
   output logic              lsb_first_o,
   output logic              done_o
);

   if (CNT_W < CNT_W_MIN) begin : g_bad_width
      $error("spi_timing_gen: CNT_W too small for the longest delay");
   end

   phase_e              phase_q;
   logic                half_q;
   logic                done_q;
   logic [ATTR_W-1:0]   attr_q;

   logic [CNT_W-1:0]              half_len;
   logic [NUM_DLY-1:0][CNT_W-1:0] dly_len;
   logic [BITS_W-1:0]             nbits;
   logic                          cpol, cpha, lsb;

   logic [CNT_W-1:0] cyc_len;
   logic             cyc_first, cyc_last;
   logic             bit_first, bit_last;
   logic             accept;

   sctg_attr_decode #(.CNT_W(CNT_W)) u_decode (
      .attr     (attr_q),
      .half_len (half_len),
      .dly_len  (dly_len),
      .nbits    (nbits),
      .cpol     (cpol),
      .cpha     (cpha),
      .lsb      (lsb)
   );

   assign accept = start_i && (phase_q == PH_IDLE);

   always_comb begin
      case (phase_q)
         PH_LEAD:  cyc_len = dly_len[0];
         PH_CLOCK: cyc_len = half_len;
         PH_TRAIL: cyc_len = dly_len[1];
         PH_GAP:   cyc_len = dly_len[2];
         default:  cyc_len = CNT_W'(1);
      endcase
   end

   sctg_span_cnt #(.W(CNT_W)) u_cyc (
      .clk     (clk_i),
      .rst_n   (rst_ni),
      .restart (accept),
      .step    (phase_q != PH_IDLE),
      .len     (cyc_len),
      .first   (cyc_first),
      .last    (cyc_last)
   );

   sctg_span_cnt #(.W(BITS_W)) u_bits (
      .clk     (clk_i),
      .rst_n   (rst_ni),
      .restart ((phase_q == PH_LEAD) && cyc_last),
      .step    ((phase_q == PH_CLOCK) && half_q && cyc_last),
      .len     (nbits),
      .first   (bit_first),
      .last    (bit_last)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         phase_q <= PH_IDLE;
         half_q  <= 1'b0;
         done_q  <= 1'b0;
         attr_q  <= '0;
      end else begin
         done_q <= 1'b0;
         case (phase_q)
            PH_IDLE: if (accept) begin
               attr_q  <= attr_i;
               phase_q <= PH_LEAD;
            end
            PH_LEAD: if (cyc_last) begin
               phase_q <= PH_CLOCK;
               half_q  <= 1'b0;
            end
            PH_CLOCK: if (cyc_last) begin
               half_q <= ~half_q;
               if (half_q && bit_last) phase_q <= PH_TRAIL;
            end
            PH_TRAIL: if (cyc_last) phase_q <= PH_GAP;
            PH_GAP: if (cyc_last) begin
               phase_q <= PH_IDLE;
               done_q  <= 1'b1;
            end
            default: phase_q <= PH_IDLE;
         endcase
      end
   end

   assign sck_o       = (phase_q == PH_CLOCK) ? (cpol ^ half_q ^ cpha) : cpol;
   assign cs_active_o = (phase_q == PH_LEAD) || (phase_q == PH_CLOCK) || (phase_q == PH_TRAIL);
   assign busy_o      = (phase_q != PH_IDLE);
   assign sample_o    = (phase_q == PH_CLOCK) && half_q && cyc_first;
   assign shift_o     = (phase_q == PH_CLOCK) && !half_q && cyc_first && (cpha || !bit_first);
   assign lsb_first_o = lsb;
   assign done_o      = done_q;

   AST_IDLE_SCK_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!busy_o && !start_i) |=> $stable(sck_o));   // R2
   AST_SAMPLE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sample_o |-> (sck_o != $past(sck_o)));   // R8
   AST_SHIFT_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      shift_o |-> (sck_o != $past(sck_o)));   // R8
   AST_STROBES_APART: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(shift_o && sample_o));   // R8
   AST_EDGE_INSIDE_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && (sck_o != $past(sck_o))) |-> cs_active_o);   // R4
   AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      done_o |-> (!busy_o ##1 !done_o));   // R11
   AST_ORDER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (busy_o && $past(busy_o)) |-> $stable(lsb_first_o));   // R10

endmodule

// File: tb/test_spi_timing_gen.sv
`timescale 1ns/1ps
module test_spi_timing_gen;

   localparam int NV = 6;
   localparam logic [30:0] ATTR [NV] = '{31'h38100010, 31'h1F8D0200, 31'h7A761100,
                                         31'h24C30001, 31'h08082103, 31'h37243124};
   localparam int NB    [NV] = '{8, 4, 16, 5, 4, 7};
   localparam int HALF  [NV] = '{2, 3, 5, 14, 8, 16};
   localparam int LEAD  [NV] = '{2, 10, 12, 14, 8, 16};
   localparam int TRAIL [NV] = '{6, 8, 28, 2, 4, 20};
   localparam int GAP   [NV] = '{4, 14, 6, 2, 10, 24};
   localparam int POL   [NV] = '{0, 1, 0, 1, 0, 1};
   localparam int PHA   [NV] = '{0, 1, 1, 0, 0, 1};
   localparam int ORD   [NV] = '{0, 1, 0, 0, 0, 1};

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [30:0] attr = '0;
   logic sck, cs, busy, shf, smp, lsbf, done;

   int errors = 0;
   int checks = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   spi_timing_gen i_spi_timing_gen (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .attr_i(attr),
      .sck_o(sck), .cs_active_o(cs), .busy_o(busy), .shift_o(shf),
      .sample_o(smp), .lsb_first_o(lsbf), .done_o(done)
   );

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one frame; optional stray start plus attribute change inside it (R3, R12)
   task automatic run_frame(int v, bit stray, bit idle_chk);
      int n_cs = 0, n_lead = 0, n_tail = 0, n_away = 0, n_gap = 0;
      int n_smp = 0, n_shf = 0, n_ord = 0, n_done = 0, busy_at_done = 0;
      bit seen = 1'b0;
      logic prev = logic'(POL[v]);
      attr  = ATTR[v];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int it = 0; it < 5000; it++) begin
         if (stray && it == 6) begin start = 1'b1; attr = '0; end
         else start = 1'b0;
         if (done) begin n_done++; busy_at_done = int'(busy); break; end
         if (cs) begin
            n_cs++;
            if (sck != logic'(POL[v])) n_away++;
            if (!seen) begin
               if (sck != logic'(POL[v])) seen = 1'b1;
               else n_lead++;
            end
            if (sck != prev) n_tail = 1;
            else n_tail++;
         end else if (busy) n_gap++;
         n_smp += int'(smp);
         n_shf += int'(shf);
         if (lsbf != logic'(ORD[v])) n_ord++;
         prev = sck;
         @(negedge clk);
      end
      start = 1'b0;
      chk($sformatf("R4 R5 R6 v%0d cs cycles", v), n_cs, LEAD[v] + 2*NB[v]*HALF[v] + TRAIL[v]);
      chk($sformatf("R5 R8 v%0d lead to first edge", v), n_lead, LEAD[v] + (PHA[v] != 0 ? 0 : HALF[v]));
      chk($sformatf("R5 R9 v%0d last edge to cs end", v), n_tail, TRAIL[v] + (PHA[v] != 0 ? HALF[v] : 0));
      chk($sformatf("R6 R9 v%0d sck away cycles", v), n_away, NB[v]*HALF[v]);
      chk($sformatf("R5 v%0d gap cycles", v), n_gap, GAP[v]);
      chk($sformatf("R7 R8 v%0d sample count", v), n_smp, NB[v]);
      chk($sformatf("R7 R8 v%0d shift count", v), n_shf, PHA[v] != 0 ? NB[v] : NB[v] - 1);
      chk($sformatf("R10 R12 v%0d bit order mismatches", v), n_ord, 0);
      chk($sformatf("R11 v%0d done seen", v), n_done, 1);
      chk($sformatf("R11 v%0d busy at done", v), busy_at_done, 0);
      if (idle_chk) begin
         for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk($sformatf("R3 v%0d no second frame", v), int'(busy), 0);
            chk($sformatf("R11 v%0d done single", v), int'(done), 0);
            chk($sformatf("R2 v%0d idle sck", v), int'(sck), POL[v]);
         end
      end
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: outputs while held in reset
      chk("R1 sck in reset", int'(sck), 0);
      chk("R1 busy in reset", int'(busy), 0);
      chk("R1 cs in reset", int'(cs), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 strobes after reset", int'(shf) + int'(smp) + int'(done) + int'(lsbf), 0);
      // R2: attribute change without start leaves sck idle
      attr = 31'h04000000;
      repeat (2) @(negedge clk);
      chk("R2 attr without start", int'(sck), 0);

      for (int v = 0; v < NV; v++) run_frame(v, 1'b1, 1'b1);

      // back-to-back: next start in the done cycle (R3, R11)
      run_frame(0, 1'b0, 1'b0);
      run_frame(4, 1'b0, 1'b1);

      // reset inside a frame returns to the reset state (R1)
      attr  = ATTR[2];
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (20) @(negedge clk);
      rst_n = 1'b0;
      #1;
      chk("R1 busy after mid-frame reset", int'(busy), 0);
      chk("R1 cs after mid-frame reset", int'(cs), 0);
      chk("R1 sck after mid-frame reset", int'(sck), 0);
      @(negedge clk);
      rst_n = 1'b1;
      run_frame(3, 1'b0, 1'b1);

      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule